// File: doc/BRIEF.md
# Four-Lane Transport Octet Remapper

This block sits in the transmit transport path of a four-lane serial converter link that carries one octet per lane in each frame. It takes converter sample words at frame rate and regroups their octets so that each lane receives one 32-bit word made of four consecutive frames. The lane words then go on to later link stages.

Two input rates are supported, and a static mode pin selects between them. In the gathering rate, one 32-bit frame arrives per accepted beat, and four accepted frames build one link word. In the wide rate, a 128-bit beat carries four frames at once, with the earliest frame in bits [31:0] and the latest in bits [127:96]. Each beat then yields one link word.

Each frame word holds two 16-bit samples. The lower sample is either sample 0 of converter 0 or the only sample of converter 0. The upper sample is either the second sample of converter 0 or sample 0 of converter 1. This changes only how the bits are labelled; the octet placement is the same in both cases.

Both edges of the block are valid/ready streams. A beat transfers on a clock edge where valid and ready are both high. Once `out_valid` is high, it stays high and `out_lanes` holds its value until `out_ready` accepts the word. In wide mode, `in_ready` follows whether the output register is free. In gathering mode, the first three frames of a group are always accepted. The fourth frame is accepted only when the output register can take the finished group.

Top module: `octet_lane_remapper`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `out_valid` low and `out_lanes` all zeros, and any partly gathered frames are discarded.
- R2: In gathering mode (`mode_div4`=0), `out_valid` rises in the cycle after the fourth accepted frame of a group, and at no other time does it rise.
- R3: For frame n, lane 0 takes bits [15:8] of the frame word, lane 1 takes bits [7:0], lane 2 takes bits [31:24] and lane 3 takes bits [23:16]. Lane l occupies `out_lanes[32l+31:32l]`.
- R4: Within a lane word, the octet of the group's first frame sits in bits [31:24] and the octet of the fourth frame sits in bits [7:0].
- R5: In wide mode (`mode_div4`=1), frame n of the group is `in_data[32n+31:32n]`, and each accepted beat makes `out_valid` high in the next cycle.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_lanes` stays unchanged.
- R7: In wide mode, `in_ready` equals (!`out_valid` || `out_ready`). In gathering mode, `in_ready` is high while fewer than three frames of the current group are held, and otherwise equals (!`out_valid` || `out_ready`).
- R8: `out_lanes` changes only in the cycle after a beat that completes a group.
- R9: In gathering mode, `in_data[127:32]` has no effect on any output.
- R10: After a reset that arrives partway through a group, the next four accepted frames form a complete group of their own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. It runs at frame rate in gathering mode and at link rate in wide mode. |
| rst | input | 1 | Active-high synchronous reset. |
| mode_div4 | input | 1 | 0 = gathering mode (one 32-bit frame per beat), 1 = wide mode (four frames per beat). It may change only while `rst` is high. |
| in_valid | input | 1 | Input beat is valid. |
| in_ready | output | 1 | The block accepts the input beat. |
| in_data | input | 128 | Frame data. Gathering mode uses only bits [31:0]. |
| out_valid | output | 1 | Lane words are valid. |
| out_ready | input | 1 | The downstream stage accepts the lane words. |
| out_lanes | output | 128 | Four 32-bit lane words, with lane 0 in the lowest bits. |

## Verification
The bench builds the block with its default parameters: four lanes of 8-bit octets, which give 32-bit frames and 128-bit beats. This is the only configuration in which the fixed octet map of R3 and R4 applies. At these values a labelled octet pattern can be checked to the exact byte in both modes. Random valid and ready timing exercises the fourth-frame back-pressure rule, stalls that last several cycles, a reset in the middle of a group, and a change of mode while reset is held.

// File: rtl/orm_pkg.sv
`timescale 1ns/1ps
package orm_pkg;
  typedef enum logic {
    MODE_GATHER = 1'b0,
    MODE_WIDE   = 1'b1
  } rate_mode_e;
endpackage

// File: rtl/orm_frame_gather.sv
`timescale 1ns/1ps
module orm_frame_gather #(
  parameter int LANES = 4,
  parameter int OCT_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  orm_pkg::rate_mode_e          mode,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [LANES*LANES*OCT_W-1:0] in_data,
  input  logic                         grp_ready,
  output logic                         grp_valid,
  output logic [LANES*LANES*OCT_W-1:0] grp_frames
);
  localparam int FRAME_W = LANES * OCT_W;
  localparam int FRAMES  = LANES;
  localparam int CNT_W   = $clog2(FRAMES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAMES - 1);

  logic [CNT_W-1:0]   slot_q;
  logic [FRAME_W-1:0] hold_q [FRAMES-1];
  logic               last_slot;
  logic               wide;
  logic               gather_fire;

  assign wide        = (mode == orm_pkg::MODE_WIDE);
  assign last_slot   = (slot_q == LAST);
  assign in_ready    = wide ? grp_ready : (!last_slot || grp_ready);
  assign grp_valid   = in_valid && (wide || last_slot);
  assign gather_fire = in_valid && in_ready && !wide;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
    end else if (gather_fire) begin
      slot_q <= last_slot ? '0 : slot_q + CNT_W'(1);
    end
  end

  for (genvar f = 0; f < FRAMES - 1; f++) begin : g_hold
    always_ff @(posedge clk) begin
      if (gather_fire && slot_q == CNT_W'(f)) begin
        hold_q[f] <= in_data[FRAME_W-1:0];
      end
    end
    assign grp_frames[f*FRAME_W +: FRAME_W] =
      wide ? in_data[f*FRAME_W +: FRAME_W] : hold_q[f];
  end

  assign grp_frames[(FRAMES-1)*FRAME_W +: FRAME_W] =
    wide ? in_data[(FRAMES-1)*FRAME_W +: FRAME_W] : in_data[FRAME_W-1:0];
endmodule

// File: rtl/orm_lane_shuffle.sv
`timescale 1ns/1ps
module orm_lane_shuffle #(
  parameter int LANES = 4,
  parameter int OCT_W = 8
) (
  input  logic [LANES*LANES*OCT_W-1:0] grp_frames,
  output logic [LANES*LANES*OCT_W-1:0] lane_words
);
  localparam int FRAME_W = LANES * OCT_W;
  localparam int FRAMES  = LANES;
  localparam int LANE_W  = FRAMES * OCT_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int SEL = l ^ 1;
    for (genvar f = 0; f < FRAMES; f++) begin : g_frame
      assign lane_words[l*LANE_W + (FRAMES-1-f)*OCT_W +: OCT_W] =
        grp_frames[f*FRAME_W + SEL*OCT_W +: OCT_W];
    end
  end
endmodule

// File: rtl/orm_out_stage.sv
`timescale 1ns/1ps
module orm_out_stage #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_valid,
  output logic         load_ready,
  input  logic [W-1:0] load_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign load_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load_valid && load_ready) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/octet_lane_remapper.sv
`timescale 1ns/1ps
module octet_lane_remapper #(
  parameter int LANES = 4,
  parameter int OCT_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         mode_div4,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [LANES*LANES*OCT_W-1:0] in_data,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [LANES*LANES*OCT_W-1:0] out_lanes
);
  localparam int BUS_W = LANES * LANES * OCT_W;

  orm_pkg::rate_mode_e mode;
  logic                grp_valid;
  logic                grp_ready;
  logic [BUS_W-1:0]    grp_frames;
  logic [BUS_W-1:0]    lane_words;

  assign mode = orm_pkg::rate_mode_e'(mode_div4);

  orm_frame_gather #(.LANES(LANES), .OCT_W(OCT_W)) gather_i (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .grp_ready  (grp_ready),
    .grp_valid  (grp_valid),
    .grp_frames (grp_frames)
  );

  orm_lane_shuffle #(.LANES(LANES), .OCT_W(OCT_W)) shuffle_i (
    .grp_frames (grp_frames),
    .lane_words (lane_words)
  );

  orm_out_stage #(.W(BUS_W)) stage_i (
    .clk        (clk),
    .rst        (rst),
    .load_valid (grp_valid),
    .load_ready (grp_ready),
    .load_data  (lane_words),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_lanes)
  );
endmodule

// File: rtl/orm_checker.sv
`timescale 1ns/1ps
module orm_checker #(
  parameter int LANES = 4,
  parameter int OCT_W = 8
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         mode_div4,
  input logic                         in_valid,
  input logic                         in_ready,
  input logic [LANES*LANES*OCT_W-1:0] in_data,
  input logic                         out_valid,
  input logic                         out_ready,
  input logic [LANES*LANES*OCT_W-1:0] out_lanes
);
  localparam int FRAMES = LANES;
  localparam int CNT_W  = $clog2(FRAMES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAMES - 1);

  logic [CNT_W-1:0] seen_q;
  logic             fire;
  logic             unused_data;

  assign fire        = in_valid && in_ready;
  assign unused_data = ^in_data;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= '0;
    else if (fire && !mode_div4) seen_q <= (seen_q == LAST) ? '0 : seen_q + CNT_W'(1);
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!out_valid && out_lanes == '0)); // R1

  AST_GROUP_COMPLETES: assert property (@(posedge clk) disable iff (rst)
    (!mode_div4 && fire && seen_q == LAST) |=> out_valid); // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !fire) |=> !out_valid); // R2

  AST_WIDE_BEAT_VALID: assert property (@(posedge clk) disable iff (rst)
    (mode_div4 && fire) |=> out_valid); // R5

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_lanes))); // R6

  AST_WIDE_READY: assert property (@(posedge clk) disable iff (rst)
    mode_div4 |-> (in_ready == (!out_valid || out_ready))); // R7

  AST_DATA_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(out_lanes)); // R8
endmodule

bind octet_lane_remapper orm_checker #(.LANES(LANES), .OCT_W(OCT_W)) chk_i (.*);

// File: tb/octet_lane_remapper_tb.sv
`timescale 1ns/1ps
module octet_lane_remapper_tb_top;
  logic         clk = 1'b0;
  logic         rst;
  logic         mode_div4;
  logic         in_valid;
  logic         in_ready;
  logic [127:0] in_data;
  logic         out_valid;
  logic         out_ready;
  logic [127:0] out_lanes;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  bit           mv;
  logic [127:0] md;
  logic [31:0]  fq[$];

  localparam logic [127:0] PAT = 128'h0c0d0e0f_08090a0b_04050607_00010203;

  always #2.5 clk = ~clk;

  octet_lane_remapper dut_i (
    .clk(clk), .rst(rst), .mode_div4(mode_div4),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_lanes(out_lanes)
  );

  function automatic logic [31:0] pat_frame(int n);
    return {8'(n + 8), 8'(n + 12), 8'(n), 8'(n + 4)};
  endfunction

  function automatic logic [127:0] map_frames(logic [31:0] fr [4]);
    logic [7:0] oct [16];
    logic [127:0] r;
    for (int n = 0; n < 4; n++) begin
      oct[n]      = fr[n][15:8];
      oct[n + 4]  = fr[n][7:0];
      oct[n + 8]  = fr[n][31:24];
      oct[n + 12] = fr[n][23:16];
    end
    for (int l = 0; l < 4; l++)
      r[32*l +: 32] = {oct[4*l], oct[4*l+1], oct[4*l+2], oct[4*l+3]};
    return r;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle(bit v, logic [127:0] d, bit r);
    bit exp_rdy, loaded;
    logic [31:0] fr [4];
    in_valid  = v;
    in_data   = d;
    out_ready = r;
    #1;
    check(mode_div4 ? "R5 valid" : "R2 valid", 128'(out_valid), 128'(mv));
    check("R3 R4 R8 R9 lanes", out_lanes, md);
    if (rst) begin
      mv = 0; md = '0; fq.delete();
    end else begin
      if (mode_div4) exp_rdy = !mv || r;
      else exp_rdy = (fq.size() < 3) || !mv || r;
      check("R7 in_ready", 128'(in_ready), 128'(exp_rdy));
      loaded = 0;
      if (v && exp_rdy) begin
        if (mode_div4) begin
          for (int n = 0; n < 4; n++) fr[n] = d[32*n +: 32];
          loaded = 1;
        end else begin
          fq.push_back(d[31:0]);
          if (fq.size() == 4) begin
            for (int n = 0; n < 4; n++) fr[n] = fq[n];
            fq.delete();
            loaded = 1;
          end
        end
      end
      if (loaded) begin
        mv = 1; md = map_frames(fr);
      end else if (mv && r) begin
        mv = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rand_run(int n, int vpct, int rpct);
    for (int i = 0; i < n; i++)
      cycle(($urandom % 100) < vpct,
            {$urandom, $urandom, $urandom, $urandom},
            ($urandom % 100) < rpct);
  endtask

  task automatic do_reset(bit m);
    rst = 1; mode_div4 = m;
    cycle(0, '0, 0);
    cycle(0, '0, 0);
    rst = 0;
  endtask

  initial begin
    logic [127:0] snap;
    void'($urandom(17));
    rst = 1; mode_div4 = 0; in_valid = 0; in_data = '0; out_ready = 0;
    mv = 0; md = '0;
    @(posedge clk);
    @(negedge clk);
    check("R1 reset valid", 128'(out_valid), 128'(0));
    check("R1 reset lanes", out_lanes, 128'(0));
    do_reset(0);

    // R2 R3 R4: labelled pattern in gathering mode
    for (int n = 0; n < 4; n++) cycle(1, {96'(0), pat_frame(n)}, 1);
    check("R2 group valid", 128'(out_valid), 128'(1));
    check("R3 R4 pattern", out_lanes, PAT);

    // R9: upper input bits carry noise
    for (int n = 0; n < 4; n++) cycle(1, {$urandom, $urandom, $urandom, pat_frame(n)}, 1);
    check("R9 upper bits ignored", out_lanes, PAT);

    rand_run(300, 70, 60);

    // R6: stall with a full output register
    for (int i = 0; i < 6; i++) cycle(0, '0, 1);
    for (int n = 0; n < 4; n++) cycle(1, {96'(0), pat_frame(n)}, 0);
    snap = out_lanes;
    for (int i = 0; i < 3; i++) cycle(1, {96'(0), pat_frame(i)}, 0);
    check("R6 valid held", 128'(out_valid), 128'(1));
    check("R6 lanes held", out_lanes, snap);
    check("R7 fourth frame blocked", 128'(in_ready), 128'(0));
    cycle(0, '0, 1);

    // R10: reset mid-group
    cycle(1, {96'(0), 32'hdeadbeef}, 1);
    cycle(1, {96'(0), 32'h12345678}, 1);
    do_reset(0);
    check("R1 cleared valid", 128'(out_valid), 128'(0));
    check("R1 cleared lanes", out_lanes, 128'(0));
    for (int n = 0; n < 4; n++) cycle(1, {96'(0), pat_frame(n)}, 1);
    check("R10 fresh group", out_lanes, PAT);

    // R5: wide mode
    do_reset(1);
    cycle(1, {pat_frame(3), pat_frame(2), pat_frame(1), pat_frame(0)}, 1);
    check("R5 wide valid", 128'(out_valid), 128'(1));
    check("R5 wide pattern", out_lanes, PAT);
    rand_run(300, 70, 60);
    rand_run(100, 90, 30);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule